// File: doc/BRIEF.md
# Interrupt Controller Setup and Command Front End

This block is the byte-wide register front end of an eight-input programmable interrupt controller. Software reaches it through two addresses, told apart by a single address bit. On the first address it writes the word that starts setup, read and poll commands, and priority commands. On the second address it writes the setup words that follow and, once setup is complete, the interrupt mask.

A small step machine walks the setup words. The step after the vector base depends on whether the controller is alone or cascaded and on whether the last setup word was asked for, so some steps are skipped. The block holds the mask, the vector base, the mode flags and the register-select flag. It forwards priority and end-of-interrupt commands to a separate priority unit as a one-cycle strobe. On a read it returns the request, in-service or mask value. When a poll is pending it returns the poll result from the priority unit instead, and the poll then clears.

Top module: `pic_front`

## Requirements
- R1: After reset the mask, vector base and all mode flags are 0, the setup step is 0, register select chooses the request register, and the command strobe, deassert pulse and level error are low.
- R2: A write to address 0 with bit 4 set starts setup. In the next cycle the step is 1 and mask, base, register select, poll, special mask, auto end-of-interrupt and nested mode are cleared. Single mode takes bit 1 and need-last-word takes bit 0, and `deassertIrq` is high for exactly that one cycle.
- R3: A setup-start write with bit 3 set raises `levelErr`. A setup-start write with bit 3 clear lowers it again.
- R4: A write to address 0 with bit 4 clear and bit 3 set is a read/poll command. Bit 2 set arms poll. If bit 1 is set, register select takes bit 0 (1 = in-service). If bit 6 is set, special mask takes bit 5. Otherwise each of these flags keeps its value.
- R5: A write to address 0 with bits 4 and 3 clear gives `cmdValid` high for one cycle on the next cycle, with `cmdCode` = bits 7:5 and `cmdOperand` = bits 2:0. The mask and step do not change.
- R6: A write to address 1 in step 0 loads the mask with the written byte.
- R7: A write to address 1 in step 1 loads the vector base with the byte ANDed with 0xF8. The next step is 2 if cascaded, 3 if single with the last word needed, and 0 otherwise.
- R8: A write to address 1 in step 2 moves to step 3 if the last word is needed, and to step 0 otherwise. It does not change the mask.
- R9: A write to address 1 in step 3 sets nested mode from bit 4 and auto end-of-interrupt from bit 1, then returns to step 0.
- R10: Read data is combinational. With poll pending, a read returns `pollIn`, `pollAck` is high while the read strobe is high, and poll is clear from the next cycle on. Without poll pending, address 0 returns `isrIn` when register select is 1 and `irrIn` when it is 0, and address 1 returns the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | One-cycle write strobe |
| rdEn | input | 1 | One-cycle read strobe |
| addr | input | 1 | Address bit choosing port 0 or port 1 |
| wrData | input | 8 | Write byte |
| irrIn | input | 8 | Request register from the priority unit |
| isrIn | input | 8 | In-service register from the priority unit |
| pollIn | input | 8 | Poll result from the priority unit |
| rdData | output | 8 | Read byte |
| pollAck | output | 1 | A read consumed a pending poll |
| cmdValid | output | 1 | Priority command strobe |
| cmdCode | output | 3 | Priority command code |
| cmdOperand | output | 3 | Priority command level operand |
| deassertIrq | output | 1 | Pulse to drop the interrupt line on setup start |
| levelErr | output | 1 | Unsupported level-triggered mode was requested |
| intMask | output | 8 | Interrupt mask |
| vectorBase | output | 8 | Vector base, low three bits zero |
| initStep | output | 2 | Setup step |
| singleMode | output | 1 | Controller is alone, not cascaded |
| needWord4 | output | 1 | Last setup word expected |
| autoEoi | output | 1 | Automatic end-of-interrupt mode |
| nestedMode | output | 1 | Special fully nested mode |
| specialMask | output | 1 | Special mask mode |
| pollPending | output | 1 | Poll armed for the next read |
| readIsr | output | 1 | Register select: 1 in-service, 0 request |

## Verification
The bench walks the setup sequence through all four combinations of single/cascaded and with/without the last word. A design that mis-routes the step skip would load a setup word into the mask, or leave the step machine stuck away from 0. It checks that the base drops its low three bits, that a restart clears a mask written earlier, and that read/poll commands with the enable bits clear leave register select and special mask alone. A decoder that ignored those enables would flip the flags. A poll read must return the poll byte exactly once and then fall back to the request register. The priority strobe must last one cycle and leave the mask untouched.

// File: rtl/pic_front_pkg.sv
package pic_front_pkg;
  localparam int DataW = 8;
  localparam int StepW = 2;
  localparam int CodeW = 3;
  localparam logic [DataW-1:0] BaseKeep = ~DataW'((1 << CodeW) - 1);

  typedef logic [StepW-1:0] step_t;
  localparam step_t StepIdle  = step_t'(0);
  localparam step_t StepBase  = step_t'(1);
  localparam step_t StepCasc  = step_t'(2);
  localparam step_t StepWord4 = step_t'(3);

  typedef struct packed {
    logic startInit;
    logic loadMask;
    logic loadBase;
    logic loadWord4;
    logic readCmd;
    logic prioCmd;
    logic pollDone;
  } strobe_t;
endpackage

// File: rtl/pic_front_ctrl.sv
module pic_front_ctrl
  import pic_front_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrEn,
  input  logic    rdEn,
  input  logic    addr,
  input  logic    initBit,
  input  logic    cmdBit,
  input  logic    singleMode,
  input  logic    needWord4,
  input  logic    pollPending,
  output strobe_t stb,
  output step_t   initStep
);
  logic  port0Wr, port1Wr;
  step_t nextStep;

  assign port0Wr = wrEn && !addr;
  assign port1Wr = wrEn && addr;

  always_comb begin
    stb           = '0;
    stb.startInit = port0Wr && initBit;
    stb.readCmd   = port0Wr && !initBit && cmdBit;
    stb.prioCmd   = port0Wr && !initBit && !cmdBit;
    stb.loadMask  = port1Wr && (initStep == StepIdle);
    stb.loadBase  = port1Wr && (initStep == StepBase);
    stb.loadWord4 = port1Wr && (initStep == StepWord4);
    stb.pollDone  = rdEn && pollPending;
  end

  always_comb begin
    nextStep = initStep;
    if (stb.startInit) begin
      nextStep = StepBase;
    end else if (port1Wr) begin
      case (initStep)
        StepBase:  nextStep = !singleMode ? StepCasc : (needWord4 ? StepWord4 : StepIdle);
        StepCasc:  nextStep = needWord4 ? StepWord4 : StepIdle;
        StepWord4: nextStep = StepIdle;
        default:   nextStep = StepIdle;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) initStep <= StepIdle;
    else       initStep <= nextStep;
  end
endmodule

// File: rtl/pic_front_regs.sv
module pic_front_regs
  import pic_front_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic             rdEn,
  input  logic             addr,
  input  logic [DataW-1:0] wrData,
  input  logic [DataW-1:0] irrIn,
  input  logic [DataW-1:0] isrIn,
  input  logic [DataW-1:0] pollIn,
  output logic [DataW-1:0] rdData,
  output logic             pollAck,
  output logic             cmdValid,
  output logic [CodeW-1:0] cmdCode,
  output logic [CodeW-1:0] cmdOperand,
  output logic             deassertIrq,
  output logic             levelErr,
  output logic [DataW-1:0] intMask,
  output logic [DataW-1:0] vectorBase,
  output logic             singleMode,
  output logic             needWord4,
  output logic             autoEoi,
  output logic             nestedMode,
  output logic             specialMask,
  output logic             pollPending,
  output logic             readIsr
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intMask     <= '0;
      vectorBase  <= '0;
      singleMode  <= 1'b0;
      needWord4   <= 1'b0;
      autoEoi     <= 1'b0;
      nestedMode  <= 1'b0;
      specialMask <= 1'b0;
      pollPending <= 1'b0;
      readIsr     <= 1'b0;
      levelErr    <= 1'b0;
      deassertIrq <= 1'b0;
      cmdValid    <= 1'b0;
      cmdCode     <= '0;
      cmdOperand  <= '0;
    end else begin
      deassertIrq <= stb.startInit;
      cmdValid    <= stb.prioCmd;
      if (stb.prioCmd) begin
        cmdCode    <= wrData[DataW-1 -: CodeW];
        cmdOperand <= wrData[CodeW-1:0];
      end
      if (stb.pollDone) pollPending <= 1'b0;
      if (stb.startInit) begin
        intMask     <= '0;
        vectorBase  <= '0;
        autoEoi     <= 1'b0;
        nestedMode  <= 1'b0;
        specialMask <= 1'b0;
        pollPending <= 1'b0;
        readIsr     <= 1'b0;
        singleMode  <= wrData[1];
        needWord4   <= wrData[0];
        levelErr    <= wrData[3];
      end
      if (stb.readCmd) begin
        if (wrData[2]) pollPending <= 1'b1;
        if (wrData[1]) readIsr <= wrData[0];
        if (wrData[6]) specialMask <= wrData[5];
      end
      if (stb.loadMask)  intMask <= wrData;
      if (stb.loadBase)  vectorBase <= wrData & BaseKeep;
      if (stb.loadWord4) begin
        nestedMode <= wrData[4];
        autoEoi    <= wrData[1];
      end
    end
  end

  assign pollAck = stb.pollDone;

  always_comb begin
    if (pollPending)  rdData = pollIn;
    else if (addr)    rdData = intMask;
    else if (readIsr) rdData = isrIn;
    else              rdData = irrIn;
  end

  logic unusedRd;
  assign unusedRd = rdEn;
endmodule

// File: rtl/pic_front.sv
module pic_front
  import pic_front_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic             addr,
  input  logic [DataW-1:0] wrData,
  input  logic [DataW-1:0] irrIn,
  input  logic [DataW-1:0] isrIn,
  input  logic [DataW-1:0] pollIn,
  output logic [DataW-1:0] rdData,
  output logic             pollAck,
  output logic             cmdValid,
  output logic [CodeW-1:0] cmdCode,
  output logic [CodeW-1:0] cmdOperand,
  output logic             deassertIrq,
  output logic             levelErr,
  output logic [DataW-1:0] intMask,
  output logic [DataW-1:0] vectorBase,
  output logic [StepW-1:0] initStep,
  output logic             singleMode,
  output logic             needWord4,
  output logic             autoEoi,
  output logic             nestedMode,
  output logic             specialMask,
  output logic             pollPending,
  output logic             readIsr
);
  strobe_t stb;

  pic_front_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .initBit(wrData[4]), .cmdBit(wrData[3]),
    .singleMode(singleMode), .needWord4(needWord4), .pollPending(pollPending),
    .stb(stb), .initStep(initStep)
  );

  pic_front_regs u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .irrIn(irrIn), .isrIn(isrIn), .pollIn(pollIn),
    .rdData(rdData), .pollAck(pollAck), .cmdValid(cmdValid),
    .cmdCode(cmdCode), .cmdOperand(cmdOperand), .deassertIrq(deassertIrq),
    .levelErr(levelErr), .intMask(intMask), .vectorBase(vectorBase),
    .singleMode(singleMode), .needWord4(needWord4), .autoEoi(autoEoi),
    .nestedMode(nestedMode), .specialMask(specialMask),
    .pollPending(pollPending), .readIsr(readIsr)
  );
endmodule

// File: rtl/pic_front_chk.sv
module pic_front_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       rdEn,
  input logic       addr,
  input logic [7:0] wrData,
  input logic [1:0] initStep,
  input logic [7:0] intMask,
  input logic [7:0] vectorBase,
  input logic       cmdValid,
  input logic [2:0] cmdCode,
  input logic       pollPending,
  input logic       deassertIrq
);
  // R2
  init_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addr && wrData[4]) |=> (initStep == 2'd1 && intMask == 8'h00 && deassertIrq));

  // R2
  deassert_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    deassertIrq |-> $past(wrEn && !addr && wrData[4]));

  // R5
  cmd_fwd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addr && !wrData[4] && !wrData[3]) |=> (cmdValid && cmdCode == $past(wrData[7:5])));

  // R6
  mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr && initStep == 2'd0) |=> (intMask == $past(wrData)));

  // R7
  base_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr && initStep == 2'd1) |=> (vectorBase == ($past(wrData) & 8'hF8)));

  // R10
  poll_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && pollPending && !wrEn) |=> !pollPending);
endmodule

bind pic_front pic_front_chk chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wrData(wrData), .initStep(initStep), .intMask(intMask),
  .vectorBase(vectorBase), .cmdValid(cmdValid), .cmdCode(cmdCode),
  .pollPending(pollPending), .deassertIrq(deassertIrq)
);

// File: tb/pic_front_test.sv
module pic_front_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, addr = 1'b0;
  logic [7:0] wrData = '0, irrIn = 8'h5A, isrIn = 8'hC3, pollIn = 8'h86;
  logic [7:0] rdData, intMask, vectorBase;
  logic pollAck, cmdValid, deassertIrq, levelErr;
  logic [2:0] cmdCode, cmdOperand;
  logic [1:0] initStep;
  logic singleMode, needWord4, autoEoi, nestedMode, specialMask, pollPending, readIsr;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pic_front uut (.*);

  // entry: {addr, data, expStep, expMask, expBase}
  localparam logic [26:0] VEC [15] = '{
    {1'b0, 8'h11, 2'd1, 8'h00, 8'h00},
    {1'b1, 8'h48, 2'd2, 8'h00, 8'h48},
    {1'b1, 8'h04, 2'd3, 8'h00, 8'h48},
    {1'b1, 8'h12, 2'd0, 8'h00, 8'h48},
    {1'b1, 8'hA5, 2'd0, 8'hA5, 8'h48},
    {1'b0, 8'h13, 2'd1, 8'h00, 8'h00},
    {1'b1, 8'h27, 2'd3, 8'h00, 8'h20},
    {1'b1, 8'h00, 2'd0, 8'h00, 8'h20},
    {1'b1, 8'h3C, 2'd0, 8'h3C, 8'h20},
    {1'b0, 8'h12, 2'd1, 8'h00, 8'h00},
    {1'b1, 8'hFF, 2'd0, 8'h00, 8'hF8},
    {1'b0, 8'h10, 2'd1, 8'h00, 8'h00},
    {1'b1, 8'h08, 2'd2, 8'h00, 8'h08},
    {1'b1, 8'h55, 2'd0, 8'h00, 8'h08},
    {1'b1, 8'h55, 2'd0, 8'h55, 8'h08}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 step", initStep, 0);
    check("R1 mask", intMask, 0);
    check("R1 base", vectorBase, 0);
    check("R1 flags", {singleMode, needWord4, autoEoi, nestedMode, specialMask, pollPending, readIsr}, 0);
    check("R1 pulses", {cmdValid, deassertIrq, levelErr}, 0);
    check("R1 read irr", rdData, 8'h5A);

    // table: R2 R6 R7 R8 R9 sequences
    for (int i = 0; i < 15; i++) begin
      wr(VEC[i][26], VEC[i][25:18]);
      check($sformatf("R2/R6/R7/R8/R9 table %0d step", i), initStep, VEC[i][17:16]);
      check($sformatf("R2/R6/R7/R8/R9 table %0d mask", i), intMask, VEC[i][15:8]);
      check($sformatf("R2/R6/R7/R8/R9 table %0d base", i), vectorBase, VEC[i][7:0]);
    end

    // R2 deassert pulse and latched flags
    wr(1'b0, 8'h13);
    check("R2 deassert high", deassertIrq, 1);
    check("R2 single/word4", {singleMode, needWord4}, 2'b11);
    @(negedge clk);
    check("R2 deassert one cycle", deassertIrq, 0);
    // R9 last word flags
    wr(1'b1, 8'h40);
    wr(1'b1, 8'h12);
    check("R9 nested/aeoi", {nestedMode, autoEoi}, 2'b11);
    check("R9 step", initStep, 0);
    wr(1'b0, 8'h11); wr(1'b1, 8'h00); wr(1'b1, 8'h00); wr(1'b1, 8'h10);
    check("R9 nested only", {nestedMode, autoEoi}, 2'b10);
    check("R8 cascaded mask untouched", intMask, 0);

    // R3 level error
    wr(1'b0, 8'h18);
    check("R3 level set", levelErr, 1);
    wr(1'b0, 8'h10);
    check("R3 level clear", levelErr, 0);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'h00);
    check("R8 step0 no word4", initStep, 0);
    wr(1'b1, 8'h0F);

    // R4 read commands
    wr(1'b0, 8'h0B);
    check("R4 select isr", readIsr, 1);
    check("R10 read isr", rdData, 8'hC3);
    wr(1'b0, 8'h08);
    check("R4 select unchanged", readIsr, 1);
    wr(1'b0, 8'h68);
    check("R4 special mask set", specialMask, 1);
    wr(1'b0, 8'h28);
    check("R4 special mask kept", specialMask, 1);
    wr(1'b0, 8'h48);
    check("R4 special mask clear", specialMask, 0);
    wr(1'b0, 8'h0A);
    check("R10 read irr", rdData, 8'h5A);
    @(negedge clk); addr = 1'b1; #1;
    check("R10 read mask", rdData, 8'h0F);

    // R10 poll
    wr(1'b0, 8'h0C);
    check("R4 poll armed", pollPending, 1);
    addr = 1'b0; rdEn = 1'b1; #1;
    check("R10 poll data", rdData, 8'h86);
    check("R10 poll ack", pollAck, 1);
    @(negedge clk); rdEn = 1'b0; #1;
    check("R10 poll cleared", pollPending, 0);
    check("R10 after poll irr", rdData, 8'h5A);

    // R5 priority command
    wr(1'b0, 8'hE3);
    check("R5 valid", cmdValid, 1);
    check("R5 code/operand", {cmdCode, cmdOperand}, 6'b111_011);
    check("R5 mask untouched", intMask, 8'h0F);
    @(negedge clk);
    check("R5 one cycle", cmdValid, 0);
    wr(1'b0, 8'h25);
    check("R5 code/operand 2", {cmdValid, cmdCode, cmdOperand}, 7'b1_001_101);
    check("R5 step untouched", initStep, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule